// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block collects interrupt requests for a processor core. Six active-low external pins, six internal peripheral pulses (two serial ports with separate transmit and receive, a byte DMA engine and a timer), a core-reset request and a power-down request feed twelve vectors. Event-style requests are latched as pending. Level-style requests follow their pin. The block gates the pending set with per-vector masks and a global enable, and presents the highest-priority eligible vector to the core as a request plus an index. The index holds until the core acknowledges it.

Each external pin has its own sensitivity rule. Three pins (X0, X1, X2) can each be set to edge or level mode. Two pins (L0, L1) are always level-sensitive. One pin (E) is always edge-sensitive. X1 and X2 share vectors with the transmit and receive of serial port 1, and a select input chooses which of the two drives those vectors. Software can set or clear any latched pending bit through a force port. Core reset and power-down pass through both the global enable and the masks.

Top module: `prio_irq_ctrl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `pending`, `irq` and `vec` are all zero.
- R2: A one-cycle pulse on `core_rst_req`, `pdown_req` or `per_req[i]` sets its pending bit on the clock edge that samples it. The bit stays set until it is cleared. Peripheral mapping: `per_req` bits 0..5 drive vectors 5, 6, 8, 9, 10, 11.
- R3: Pins are active low. Each pin passes through two synchronizing flops, and an edge event is a registered high-to-low change. The pending bit of an edge-mode pin rises on the third clock edge after the pin falls.
- R4: For a level-mode pin (L0 at vector 3, L1 at vector 4, and X0/X1/X2 when their mode bit is 0), the pending bit equals the synchronized pin state, two edges late. Nothing is latched, and the bit drops when the pin is released, with no acknowledge.
- R5: `edge_sel` bits 0..2 put X0 (vector 2), X1 and X2 into edge mode when 1. Pin E (vector 7) is always edge mode. Pin indices in `pin_n`: 0=X0, 1=X1, 2=X2, 3=L0, 4=L1, 5=E.
- R6: Priority is fixed: a lower vector index wins. Vector 0 is core reset and vector 1 is power-down.
- R7: Vectors 2..11 are eligible only when `glob_en` is 1 and their bit `mask[v-2]` is 1.
- R8: Vectors 0 and 1 are eligible whenever pending, regardless of `glob_en` and `mask`.
- R9: When `irq` is low and some vector is eligible, `irq` rises on the next edge with `vec` set to the best eligible index. While `irq` is high, `vec` does not change.
- R10: `ack` sampled with `irq` high drops `irq` on the next edge and clears only the latched pending bit of `vec`. `ack` with `irq` low has no effect.
- R11: With `force_wr` high, `force_set` sets and `force_clr` clears latched pending bits, for latched-style vectors only. In any one edge, a set (event or force) beats a clear (acknowledge or force).
- R12: With `alt_pins` at 1, vectors 9 and 10 are driven by pins X1 and X2. With `alt_pins` at 0, they are driven by `per_req` bits 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_n | input | 6 | Active-low external request pins |
| core_rst_req | input | 1 | Core reset request pulse (vector 0) |
| pdown_req | input | 1 | Power-down request pulse (vector 1) |
| per_req | input | 6 | Internal peripheral request pulses |
| edge_sel | input | 3 | Edge (1) or level (0) mode for X0, X1, X2 |
| alt_pins | input | 1 | Route X1/X2 to vectors 9/10 instead of serial port 1 |
| glob_en | input | 1 | Global enable for maskable vectors |
| mask | input | 10 | Per-vector enable for vectors 2..11 |
| force_wr | input | 1 | Apply force set/clear this cycle |
| force_set | input | 12 | Pending bits to set |
| force_clr | input | 12 | Pending bits to clear |
| ack | input | 1 | Core acknowledge of the current vector |
| irq | output | 1 | Interrupt request to the core |
| vec | output | 4 | Index of the vector being requested |
| pending | output | 12 | Latched and level pending view |

## Verification
The bench aims at the point where a higher-priority request arrives while a lower one is already presented. A design that re-encoded every cycle would change `vec` under the core's feet. The bench lines up an acknowledge with a fresh event on the same vector: a design that lets the clear win would drop that event. It also toggles level-mode pins with no acknowledge, which a design that latched them would leave stuck. Reset and power-down are raised while everything is masked, and X1/X2 are moved between their pin and serial-port roles, to expose wrong gating and wrong routing.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int NUM_VEC = 12;
    localparam int VEC_W   = $clog2(NUM_VEC);
    localparam int NUM_PIN = 6;
    localparam int NUM_PER = 6;
    localparam int NUM_CFG = 3;

    // vector indices, lower index = higher priority
    localparam int V_RST = 0;
    localparam int V_PWD = 1;
    localparam int V_X0  = 2;
    localparam int V_L0  = 3;
    localparam int V_L1  = 4;
    localparam int V_S0T = 5;
    localparam int V_S0R = 6;
    localparam int V_EDG = 7;
    localparam int V_DMA = 8;
    localparam int V_S1T = 9;
    localparam int V_S1R = 10;
    localparam int V_TMR = 11;

    // pin indices inside pin_n
    localparam int P_X0 = 0;
    localparam int P_X1 = 1;
    localparam int P_X2 = 2;
    localparam int P_L0 = 3;
    localparam int P_L1 = 4;
    localparam int P_E  = 5;

    // peripheral indices inside per_req
    localparam int Q_S0T = 0;
    localparam int Q_S0R = 1;
    localparam int Q_DMA = 2;
    localparam int Q_S1T = 3;
    localparam int Q_S1R = 4;
    localparam int Q_TMR = 5;

    typedef struct packed {
        logic             hit;
        logic [VEC_W-1:0] idx;
    } grant_t;

    function automatic grant_t first_set(input logic [NUM_VEC-1:0] req);
        grant_t g;
        g = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (req[i]) begin
                g.hit = 1'b1;
                g.idx = VEC_W'(i);
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/pic_pin_sync.sv
module pic_pin_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_n,
    output logic [W-1:0] act,
    output logic [W-1:0] fall
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2, pv;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                pv <= 1'b0;
            end else begin
                s1 <= ~pin_n[i];
                s2 <= s1;
                pv <= s2;
            end
        end
        assign act[i]  = s2;
        assign fall[i] = s2 & ~pv;
    end
endmodule

// File: rtl/pic_pend_bank.sv
module pic_pend_bank #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] keep,
    input  logic [W-1:0] set_ev,
    input  logic [W-1:0] clr_ev,
    output logic [W-1:0] stored
);
    always_ff @(posedge clk) begin
        if (rst) stored <= '0;
        else     stored <= ((stored & ~clr_ev) | set_ev) & keep;
    end
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc
    import pic_pkg::*;
(
    input  logic [NUM_VEC-1:0] req,
    output grant_t             grant
);
    always_comb grant = first_set(req);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PIN-1:0]   pin_n,
    input  logic                 core_rst_req,
    input  logic                 pdown_req,
    input  logic [NUM_PER-1:0]   per_req,
    input  logic [NUM_CFG-1:0]   edge_sel,
    input  logic                 alt_pins,
    input  logic                 glob_en,
    input  logic [NUM_VEC-3:0]   mask,
    input  logic                 force_wr,
    input  logic [NUM_VEC-1:0]   force_set,
    input  logic [NUM_VEC-1:0]   force_clr,
    input  logic                 ack,
    output logic                 irq,
    output logic [VEC_W-1:0]     vec,
    output logic [NUM_VEC-1:0]   pending
);
    logic [NUM_PIN-1:0] act, fall;
    logic [NUM_VEC-1:0] latch_ok, raw_ev, set_ev, clr_ev, lvl_view, stored, enab, elig;
    logic               irq_q;
    logic [VEC_W-1:0]   vec_q;
    grant_t             grant;

    pic_pin_sync #(.W(NUM_PIN)) u_sync (
        .clk(clk), .rst(rst), .pin_n(pin_n), .act(act), .fall(fall)
    );

    always_comb begin
        latch_ok        = '1;
        latch_ok[V_X0]  = edge_sel[0];
        latch_ok[V_L0]  = 1'b0;
        latch_ok[V_L1]  = 1'b0;
        if (alt_pins) begin
            latch_ok[V_S1T] = edge_sel[1];
            latch_ok[V_S1R] = edge_sel[2];
        end

        raw_ev         = '0;
        raw_ev[V_RST]  = core_rst_req;
        raw_ev[V_PWD]  = pdown_req;
        raw_ev[V_X0]   = fall[P_X0];
        raw_ev[V_L0]   = fall[P_L0];
        raw_ev[V_L1]   = fall[P_L1];
        raw_ev[V_S0T]  = per_req[Q_S0T];
        raw_ev[V_S0R]  = per_req[Q_S0R];
        raw_ev[V_EDG]  = fall[P_E];
        raw_ev[V_DMA]  = per_req[Q_DMA];
        raw_ev[V_S1T]  = alt_pins ? fall[P_X1] : per_req[Q_S1T];
        raw_ev[V_S1R]  = alt_pins ? fall[P_X2] : per_req[Q_S1R];
        raw_ev[V_TMR]  = per_req[Q_TMR];

        lvl_view         = '0;
        lvl_view[V_X0]   = act[P_X0];
        lvl_view[V_L0]   = act[P_L0];
        lvl_view[V_L1]   = act[P_L1];
        lvl_view[V_S1T]  = alt_pins & act[P_X1];
        lvl_view[V_S1R]  = alt_pins & act[P_X2];
        lvl_view         = lvl_view & ~latch_ok;
    end

    assign set_ev = raw_ev | (force_wr ? force_set : '0);
    assign clr_ev = (force_wr ? force_clr : '0)
                  | ((irq_q && ack) ? (NUM_VEC'(1) << vec_q) : '0);

    pic_pend_bank #(.W(NUM_VEC)) u_bank (
        .clk(clk), .rst(rst), .keep(latch_ok),
        .set_ev(set_ev), .clr_ev(clr_ev), .stored(stored)
    );

    assign pending = stored | lvl_view;
    assign enab    = {mask & {(NUM_VEC-2){glob_en}}, 2'b11};
    assign elig    = pending & enab;

    pic_prio_enc u_enc (.req(elig), .grant(grant));

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
            vec_q <= '0;
        end else if (irq_q) begin
            if (ack) irq_q <= 1'b0;
        end else if (grant.hit) begin
            irq_q <= 1'b1;
            vec_q <= grant.idx;
        end
    end

    assign irq = irq_q;
    assign vec = vec_q;

endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
    import pic_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               irq,
    input logic [VEC_W-1:0]   vec,
    input logic               ack,
    input logic [NUM_VEC-1:0] pending,
    input logic               glob_en,
    input logic               force_wr,
    input logic               core_rst_req
);
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (rst)
        irq && !ack |=> irq && $stable(vec)); // R9
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        irq && ack |=> !irq); // R10
    AST_RST_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        pending[V_RST] && !irq |=> irq); // R8
    AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
        !irq && !glob_en && pending[V_PWD:V_RST] == 2'b00 |=> !irq); // R7
    AST_VEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        irq |-> vec < VEC_W'(NUM_VEC)); // R6
    AST_ACK_CLEARS_RST: assert property (@(posedge clk) disable iff (rst)
        irq && ack && vec == VEC_W'(V_RST) && !force_wr && !core_rst_req |=> !pending[V_RST]); // R10
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .irq(irq), .vec(vec), .ack(ack), .pending(pending),
    .glob_en(glob_en), .force_wr(force_wr), .core_rst_req(core_rst_req)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  pin_n = '1;
    logic        core_rst_req = 0, pdown_req = 0;
    logic [5:0]  per_req = '0;
    logic [2:0]  edge_sel = '0;
    logic        alt_pins = 0, glob_en = 0;
    logic [9:0]  mask = '0;
    logic        force_wr = 0;
    logic [11:0] force_set = '0, force_clr = '0;
    logic        ack = 0;
    logic        irq;
    logic [3:0]  vec;
    logic [11:0] pending;

    int    n_chk = 0, n_err = 0;
    string cur_req = "R1";
    bit    cmp_on = 0;
    bit    done = 0;

    always #10 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk(clk), .rst(rst), .pin_n(pin_n), .core_rst_req(core_rst_req),
        .pdown_req(pdown_req), .per_req(per_req), .edge_sel(edge_sel),
        .alt_pins(alt_pins), .glob_en(glob_en), .mask(mask), .force_wr(force_wr),
        .force_set(force_set), .force_clr(force_clr), .ack(ack),
        .irq(irq), .vec(vec), .pending(pending)
    );

    // ---------------- behavioural reference ----------------
    logic [5:0]  m_s1 = '0, m_s2 = '0, m_pv = '0;
    logic [11:0] m_st = '0;
    logic        m_irq = 0;
    int          m_vec = 0;

    function automatic bit m_latch(int v);
        case (v)
            2:       return edge_sel[0];
            3, 4:    return 0;
            9:       return alt_pins ? edge_sel[1] : 1'b1;
            10:      return alt_pins ? edge_sel[2] : 1'b1;
            default: return 1;
        endcase
    endfunction

    function automatic bit m_act(int v);
        case (v)
            2:       return m_s2[0];
            3:       return m_s2[3];
            4:       return m_s2[4];
            9:       return alt_pins && m_s2[1];
            10:      return alt_pins && m_s2[2];
            default: return 0;
        endcase
    endfunction

    function automatic bit m_fall(int p);
        return m_s2[p] && !m_pv[p];
    endfunction

    function automatic bit m_event(int v);
        case (v)
            0:  return core_rst_req;
            1:  return pdown_req;
            2:  return m_fall(0);
            3:  return m_fall(3);
            4:  return m_fall(4);
            5:  return per_req[0];
            6:  return per_req[1];
            7:  return m_fall(5);
            8:  return per_req[2];
            9:  return alt_pins ? m_fall(1) : per_req[3];
            10: return alt_pins ? m_fall(2) : per_req[4];
            default: return per_req[5];
        endcase
    endfunction

    function automatic logic [11:0] m_pending();
        logic [11:0] r;
        for (int v = 0; v < 12; v++) r[v] = m_st[v] || (!m_latch(v) && m_act(v));
        return r;
    endfunction

    always @(posedge clk) begin : model
        logic [11:0] pv, nst;
        int best;
        bit clr, setb, ok;
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_pv = '0; m_st = '0; m_irq = 0; m_vec = 0;
        end else begin
            pv = m_pending();
            best = -1;
            for (int v = 11; v >= 0; v--) begin
                ok = (v < 2) || (glob_en && mask[v-2]);
                if (pv[v] && ok) best = v;
            end
            for (int v = 0; v < 12; v++) begin
                clr  = (force_wr && force_clr[v]) || (m_irq && ack && m_vec == v);
                setb = m_event(v) || (force_wr && force_set[v]);
                nst[v] = m_latch(v) && ((m_st[v] && !clr) || setb);
            end
            m_st = nst;
            if (m_irq) begin
                if (ack) m_irq = 0;
            end else if (best >= 0) begin
                m_irq = 1;
                m_vec = best;
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = ~pin_n;
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(cur_req, "pending", int'(pending), int'(m_pending()));
            check(cur_req, "irq", int'(irq), int'(m_irq));
            check(cur_req, "vec", int'(vec), m_vec);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input int n);
        repeat (n) begin
            @(negedge clk);
            ack = irq;
        end
        @(negedge clk);
        ack = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cyc(3);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1", "pending", int'(pending), 0);
        check("R1", "irq", int'(irq), 0);
        check("R1", "vec", int'(vec), 0);
        cmp_on = 1;

        // R2 timer pulse latched, R9 raise
        cur_req = "R2";
        glob_en = 1; mask = '1;
        per_req[5] = 1;
        @(negedge clk); per_req = '0;
        check("R2", "pending timer", int'(pending[11]), 1);
        cyc(3);
        check("R2", "still pending", int'(pending[11]), 1);
        check("R9", "vec timer", int'(vec), 11);
        drain(4);

        // R6 priority among simultaneous pulses
        cur_req = "R6";
        per_req = 6'b100101;
        @(negedge clk); per_req = '0;
        @(negedge clk);
        check("R6", "vec best", int'(vec), 5);
        drain(12);

        // R3 / R5 fixed edge pin E
        cur_req = "R3";
        pin_n[5] = 0;
        cyc(2);
        check("R3", "not yet", int'(pending[7]), 0);
        @(negedge clk);
        check("R3", "edge latched", int'(pending[7]), 1);
        cyc(3); pin_n[5] = 1; cyc(3);
        check("R5", "edge sticky", int'(pending[7]), 1);
        drain(6);

        // R4 level pin L0 follows pin without ack
        cur_req = "R4";
        mask[1] = 0;
        pin_n[3] = 0; cyc(2);
        check("R4", "level on", int'(pending[3]), 1);
        pin_n[3] = 1; cyc(2);
        check("R4", "level off", int'(pending[3]), 0);
        check("R4", "no irq masked", int'(irq), 0);
        mask = '1;

        // R5 X0 in both modes
        cur_req = "R5";
        edge_sel[0] = 1; pin_n[0] = 0; cyc(4); pin_n[0] = 1; cyc(3);
        drain(6);
        edge_sel[0] = 0; pin_n[0] = 0; cyc(3); drain(3); pin_n[0] = 1; cyc(3);
        drain(4);

        // R7 global enable and mask
        cur_req = "R7";
        glob_en = 0;
        per_req[2] = 1; @(negedge clk); per_req = '0; cyc(3);
        check("R7", "gated irq", int'(irq), 0);
        glob_en = 1; mask[6] = 0; cyc(2);
        check("R7", "masked irq", int'(irq), 0);
        mask[6] = 1; cyc(2);
        check("R7", "unmasked vec", int'(vec), 8);
        drain(4);

        // R8 reset and power-down bypass gating
        cur_req = "R8";
        glob_en = 0; mask = '0;
        pdown_req = 1; @(negedge clk); pdown_req = 0; @(negedge clk);
        check("R8", "pwd irq", int'(irq), 1);
        check("R8", "pwd vec", int'(vec), 1);
        drain(3);
        glob_en = 1; mask = '1;

        // R9 vec held when higher arrives
        cur_req = "R9";
        per_req[5] = 1; @(negedge clk); per_req = '0; cyc(2);
        core_rst_req = 1; @(negedge clk); core_rst_req = 0; cyc(3);
        check("R9", "vec held", int'(vec), 11);
        ack = 1; @(negedge clk); ack = 0; @(negedge clk);
        check("R9", "next is reset", int'(vec), 0);
        drain(4);

        // R10 ack with irq low, and ack racing a new event (R11 set wins)
        cur_req = "R10";
        ack = 1; cyc(3); ack = 0;
        per_req[0] = 1; @(negedge clk); per_req = '0; @(negedge clk);
        ack = 1; per_req[0] = 1; @(negedge clk); ack = 0; per_req = '0;
        check("R10", "set beats ack", int'(pending[5]), 1);
        drain(4);

        // R11 force set / clear
        cur_req = "R11";
        mask = '0;
        force_wr = 1; force_set = 12'h9A0; @(negedge clk);
        force_set = '0; force_clr = 12'h080; @(negedge clk);
        force_wr = 0; force_clr = '0;
        check("R11", "forced", int'(pending), 'h920);
        force_wr = 1; force_clr = 12'hFFF; @(negedge clk); force_wr = 0; force_clr = '0;
        check("R11", "cleared", int'(pending), 0);
        mask = '1;

        // R12 alternate pin routing
        cur_req = "R12";
        alt_pins = 1; edge_sel[2:1] = 2'b01;
        per_req[3] = 1; @(negedge clk); per_req = '0; cyc(2);
        check("R12", "serial ignored", int'(pending[9]), 0);
        pin_n[2] = 0; cyc(2);
        check("R12", "X2 level", int'(pending[10]), 1);
        pin_n[1] = 0; cyc(4); pin_n = '1;
        drain(8);
        alt_pins = 0;

        // random mix
        cur_req = "R6";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if ($urandom_range(7) == 0) pin_n[$urandom_range(5)] ^= 1'b1;
            per_req      = ($urandom_range(5) == 0) ? 6'($urandom) : '0;
            core_rst_req = ($urandom_range(60) == 0);
            pdown_req    = ($urandom_range(60) == 0);
            ack          = irq && ($urandom_range(2) == 0);
            force_wr     = ($urandom_range(15) == 0);
            force_set    = 12'($urandom) & 12'($urandom);
            force_clr    = 12'($urandom);
            if ($urandom_range(40) == 0) glob_en = ~glob_en;
            if ($urandom_range(30) == 0) mask = 10'($urandom);
            if ($urandom_range(80) == 0) edge_sel = 3'($urandom);
            if ($urandom_range(80) == 0) alt_pins = ~alt_pins;
        end
        @(negedge clk);
        finish_run();
    end
endmodule